// File: doc/BRIEF.md
# Trap and Interrupt Entry Unit

This block sits beside a hart's control-status state and decides, once per cycle, whether a trap is taken and at which privilege level it is handled. It takes the raw inputs: the pending and enable interrupt vectors, the two delegation masks, the current privilege and interrupt-enable status bits, and a synchronous exception request. It works out the single winning event and registers the complete set of trap-entry writes.

An exception request has priority over any interrupt in the same cycle. Among the interrupts that the level rules allow, the lowest-numbered line wins. The destination is supervisor level when the current privilege is supervisor or user and the cause is delegated. Otherwise it is machine level.

All entry writes land on one clock edge. The writes are the new PC, the new privilege, the saved previous-enable and previous-privilege fields, the cleared enable bit, and the cause, EPC and bad-address values, each with a one-cycle write strobe. A breakpoint exception takes no trap. It only sets a sticky halt flag.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset, trap_fire, trap_wr_s, trap_wr_m, trap_wr_bad and halted are 0, trap_priv is 3 (machine), and the PC, cause, EPC, bad-address and status outputs are 0.
- R2: The candidate set is irq_pend AND irq_en. The lowest-numbered allowed line is taken, and its cause word is the line index with bit XLEN-1 set.
- R3: A line whose irq_deleg bit is 0 is allowed when cur_priv is user (0) or supervisor (1), or when it is machine (3) with st_mie set.
- R4: A line whose irq_deleg bit is 1 is allowed when cur_priv is user, or when it is supervisor with st_sie set. It is never allowed at machine level.
- R5: A trap goes to supervisor only when cur_priv is 0 or 1 and the delegation bit is set. Exceptions index exc_deleg with the cause value, and interrupts index irq_deleg with the line index. An exception cause of XLEN or more always goes to machine.
- R6: On supervisor entry, the unit sets trap_pc to the stvec input and trap_priv to 1. trap_spie gets the enable bit of the level being left (st_uie for 0, st_sie for 1). trap_spp gets bit 0 of the old privilege, and trap_sie becomes 0. The machine fields pass through from the inputs.
- R7: On machine entry, the unit sets trap_pc to the mtvec input and trap_priv to 3. trap_mpie gets the enable bit of the level being left (st_uie, st_sie or st_mie for 0, 1 or 3). trap_mpp gets the old privilege, and trap_mie becomes 0. The supervisor fields pass through from the inputs.
- R8: trap_wr_bad pulses and trap_bad is loaded only for a non-breakpoint exception with exc_has_bad set. Interrupts never write it, and trap_bad otherwise holds its value.
- R9: An exception with cause 3 (breakpoint) takes no trap and leaves every trap output unchanged. It sets halted, which stays 1 until reset.
- R10: When exc_req is high in the same cycle as an allowed interrupt, the exception is taken, and the cause is exc_cause with the EPC from exc_epc. For interrupts the EPC comes from cur_pc.
- R11: All outputs of a decision made in cycle t appear after the edge ending cycle t. trap_fire is high in the following cycle only if a trap was taken, and exactly one of trap_wr_s and trap_wr_m accompanies it.
- R12: trap_pc is the selected vector with its two low bits forced to 0.
- R13: With no allowed interrupt and no exception request, no strobe rises and the PC, privilege, cause, EPC and status outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pend | input | NIRQ | Pending interrupt lines |
| irq_en | input | NIRQ | Interrupt enable lines |
| irq_deleg | input | NIRQ | Interrupt delegation mask (1 = supervisor) |
| exc_deleg | input | XLEN | Exception delegation mask indexed by cause |
| cur_priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| st_uie | input | 1 | User interrupt enable |
| st_sie | input | 1 | Supervisor interrupt enable |
| st_mie | input | 1 | Machine interrupt enable |
| st_spie | input | 1 | Supervisor previous enable (current) |
| st_spp | input | 1 | Supervisor previous privilege (current) |
| st_mpie | input | 1 | Machine previous enable (current) |
| st_mpp | input | 2 | Machine previous privilege (current) |
| stvec | input | XLEN | Supervisor trap vector |
| mtvec | input | XLEN | Machine trap vector |
| cur_pc | input | XLEN | PC saved as EPC for an interrupt |
| exc_req | input | 1 | Synchronous exception request |
| exc_cause | input | XLEN | Exception cause code |
| exc_epc | input | XLEN | Faulting PC of the exception |
| exc_has_bad | input | 1 | Exception supplies a bad address |
| exc_bad | input | XLEN | Bad address value |
| trap_fire | output | 1 | A trap was entered on the last edge |
| trap_wr_s | output | 1 | Supervisor cause/EPC write strobe |
| trap_wr_m | output | 1 | Machine cause/EPC write strobe |
| trap_wr_bad | output | 1 | Bad-address write strobe |
| trap_pc | output | XLEN | New PC |
| trap_priv | output | 2 | New privilege |
| trap_cause | output | XLEN | Cause value written |
| trap_epc | output | XLEN | EPC value written |
| trap_bad | output | XLEN | Bad-address value written |
| trap_sie | output | 1 | Updated supervisor enable |
| trap_spie | output | 1 | Updated supervisor previous enable |
| trap_spp | output | 1 | Updated supervisor previous privilege |
| trap_mie | output | 1 | Updated machine enable |
| trap_mpie | output | 1 | Updated machine previous enable |
| trap_mpp | output | 2 | Updated machine previous privilege |
| halted | output | 1 | Sticky breakpoint halt |

## Verification
The assertions assume that cur_priv never carries the reserved value 2 and that an exception cause never has bit XLEN-1 set, since that bit is reserved for interrupt causes. They also assume that NIRQ does not exceed XLEN. The stimulus draws privileges only from 0, 1 and 3 and keeps every exception cause well below 2^31, and the sweeps cover causes above XLEN only through their low value range. Interrupt patterns come from exhaustive single-line sweeps and from a shift-register sequence whose privilege field is remapped away from 2.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_H = 2'b10,
    PRIV_M = 2'b11
  } priv_e;

  typedef struct packed {
    logic       uie;
    logic       sie;
    logic       mie;
    logic       spie;
    logic       spp;
    logic       mpie;
    logic [1:0] mpp;
  } status_t;

  // a level accepts interrupts when running below it, or at it with its enable set
  function automatic logic level_open(input logic [1:0] cur, input logic [1:0] lvl,
                                      input logic ie);
    return (cur < lvl) || ((cur == lvl) && ie);
  endfunction

  // enable bit belonging to a privilege level
  function automatic logic ie_of(input status_t st, input logic [1:0] p);
    case (p)
      2'b00:   return st.uie;
      2'b01:   return st.sie;
      2'b11:   return st.mie;
      default: return 1'b0;
    endcase
  endfunction

  function automatic status_t enter_s(input status_t st, input logic [1:0] p);
    status_t r;
    r      = st;
    r.spie = ie_of(st, p);
    r.spp  = p[0];
    r.sie  = 1'b0;
    return r;
  endfunction

  function automatic status_t enter_m(input status_t st, input logic [1:0] p);
    status_t r;
    r      = st;
    r.mpie = ie_of(st, p);
    r.mpp  = p;
    r.mie  = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/trap_irq_pick.sv
module trap_irq_pick
  import trap_pkg::*;
#(
  parameter int NIRQ = 12,
  parameter int IW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] pend,
  input  logic [NIRQ-1:0] en,
  input  logic [NIRQ-1:0] deleg,
  input  logic [1:0]      cur_priv,
  input  status_t         st,
  output logic            hit,
  output logic [IW-1:0]   idx,
  output logic [NIRQ-1:0] allowed
);

  logic            m_open;
  logic            s_open;
  logic [NIRQ-1:0] cand;

  function automatic logic [IW-1:0] lowest(input logic [NIRQ-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = NIRQ - 1; i >= 0; i--) begin
      if (v[i]) r = IW'(i);
    end
    return r;
  endfunction

  function automatic logic [NIRQ-1:0] below(input logic [IW-1:0] k);
    return (NIRQ'(1) << k) - NIRQ'(1);
  endfunction

  assign m_open  = level_open(cur_priv, PRIV_M, st.mie);
  assign s_open  = level_open(cur_priv, PRIV_S, st.sie);
  assign cand    = pend & en;
  assign allowed = (cand & ~deleg & {NIRQ{m_open}}) | (cand & deleg & {NIRQ{s_open}});
  assign hit     = |allowed;
  assign idx     = lowest(allowed);

  // R2
  pick_in_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> allowed[idx]);

  // R2
  pick_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((allowed & below(idx)) == '0));

  // R3
  mach_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_priv == PRIV_M && !st.mie) |-> ((allowed & ~deleg) == '0));

  // R4
  sup_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_priv == PRIV_M || (cur_priv == PRIV_S && !st.sie)) |-> ((allowed & deleg) == '0));

endmodule

// File: rtl/trap_route.sv
module trap_route
  import trap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NIRQ = 12,
  parameter int IW   = 4,
  parameter int BKPT = 3
) (
  input  logic            exc_req,
  input  logic [XLEN-1:0] exc_cause,
  input  logic [XLEN-1:0] exc_deleg,
  input  logic            irq_hit,
  input  logic [IW-1:0]   irq_idx,
  input  logic [NIRQ-1:0] irq_deleg,
  input  logic [1:0]      cur_priv,
  output logic            take,
  output logic            is_irq,
  output logic            to_s,
  output logic            bkpt,
  output logic [XLEN-1:0] cause_word
);

  localparam int CIW = $clog2(XLEN);
  localparam logic [XLEN-1:0] IRQ_FLAG = {1'b1, {(XLEN-1){1'b0}}};

  logic deleg_bit;
  logic low_priv;

  assign bkpt   = exc_req && (exc_cause == XLEN'(BKPT));
  assign is_irq = !exc_req && irq_hit;
  assign take   = (exc_req && !bkpt) || is_irq;

  always_comb begin
    deleg_bit = 1'b0;
    if (is_irq)
      deleg_bit = irq_deleg[irq_idx];
    else if (exc_cause < XLEN'(XLEN))
      deleg_bit = exc_deleg[exc_cause[CIW-1:0]];
  end

  assign low_priv   = (cur_priv == PRIV_U) || (cur_priv == PRIV_S);
  assign to_s       = take && low_priv && deleg_bit;
  assign cause_word = is_irq ? (IRQ_FLAG | XLEN'(irq_idx)) : exc_cause;

endmodule

// File: rtl/trap_commit.sv
module trap_commit
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            to_s,
  input  logic            is_irq,
  input  logic            bkpt,
  input  logic [XLEN-1:0] cause_word,
  input  logic [XLEN-1:0] exc_epc,
  input  logic [XLEN-1:0] cur_pc,
  input  logic            has_bad,
  input  logic [XLEN-1:0] bad_addr,
  input  logic [XLEN-1:0] stvec,
  input  logic [XLEN-1:0] mtvec,
  input  logic [1:0]      cur_priv,
  input  status_t         st,
  output logic            fire_q,
  output logic            wr_s_q,
  output logic            wr_m_q,
  output logic            wr_bad_q,
  output logic [XLEN-1:0] pc_q,
  output logic [1:0]      priv_q,
  output logic [XLEN-1:0] cause_q,
  output logic [XLEN-1:0] epc_q,
  output logic [XLEN-1:0] bad_q,
  output status_t         st_q,
  output logic            halted_q
);

  logic bad_wr;

  function automatic logic [XLEN-1:0] align4(input logic [XLEN-1:0] v);
    return {v[XLEN-1:2], 2'b00};
  endfunction

  assign bad_wr = take && !is_irq && has_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fire_q   <= 1'b0;
      wr_s_q   <= 1'b0;
      wr_m_q   <= 1'b0;
      wr_bad_q <= 1'b0;
      pc_q     <= '0;
      priv_q   <= PRIV_M;
      cause_q  <= '0;
      epc_q    <= '0;
      bad_q    <= '0;
      st_q     <= '0;
      halted_q <= 1'b0;
    end else begin
      fire_q   <= take;
      wr_s_q   <= take && to_s;
      wr_m_q   <= take && !to_s;
      wr_bad_q <= bad_wr;
      if (bkpt) halted_q <= 1'b1;
      if (take) begin
        pc_q    <= align4(to_s ? stvec : mtvec);
        priv_q  <= to_s ? PRIV_S : PRIV_M;
        cause_q <= cause_word;
        epc_q   <= is_irq ? cur_pc : exc_epc;
        st_q    <= to_s ? enter_s(st, cur_priv) : enter_m(st, cur_priv);
      end
      if (bad_wr) bad_q <= bad_addr;
    end
  end

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted_q |=> halted_q);

  // R9
  bkpt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bkpt |=> (!fire_q && halted_q));

  // R6
  s_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_s_q |-> (priv_q == PRIV_S && !st_q.sie));

  // R7
  m_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_m_q |-> (priv_q == PRIV_M && !st_q.mie));

  // R11
  one_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> ($countones({wr_s_q, wr_m_q}) == 1));

  // R8
  bad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_bad_q |-> $stable(bad_q));

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NIRQ = 12,
  parameter int BKPT = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] irq_pend,
  input  logic [NIRQ-1:0] irq_en,
  input  logic [NIRQ-1:0] irq_deleg,
  input  logic [XLEN-1:0] exc_deleg,
  input  logic [1:0]      cur_priv,
  input  logic            st_uie,
  input  logic            st_sie,
  input  logic            st_mie,
  input  logic            st_spie,
  input  logic            st_spp,
  input  logic            st_mpie,
  input  logic [1:0]      st_mpp,
  input  logic [XLEN-1:0] stvec,
  input  logic [XLEN-1:0] mtvec,
  input  logic [XLEN-1:0] cur_pc,
  input  logic            exc_req,
  input  logic [XLEN-1:0] exc_cause,
  input  logic [XLEN-1:0] exc_epc,
  input  logic            exc_has_bad,
  input  logic [XLEN-1:0] exc_bad,
  output logic            trap_fire,
  output logic            trap_wr_s,
  output logic            trap_wr_m,
  output logic            trap_wr_bad,
  output logic [XLEN-1:0] trap_pc,
  output logic [1:0]      trap_priv,
  output logic [XLEN-1:0] trap_cause,
  output logic [XLEN-1:0] trap_epc,
  output logic [XLEN-1:0] trap_bad,
  output logic            trap_sie,
  output logic            trap_spie,
  output logic            trap_spp,
  output logic            trap_mie,
  output logic            trap_mpie,
  output logic [1:0]      trap_mpp,
  output logic            halted
);

  localparam int IW = (NIRQ > 1) ? $clog2(NIRQ) : 1;

  status_t         st_in;
  status_t         st_out;
  logic            irq_hit;
  logic [IW-1:0]   irq_idx;
  logic [NIRQ-1:0] irq_allowed;
  logic            take;
  logic            is_irq;
  logic            to_s;
  logic            bkpt;
  logic [XLEN-1:0] cause_word;

  always_comb begin
    st_in      = '0;
    st_in.uie  = st_uie;
    st_in.sie  = st_sie;
    st_in.mie  = st_mie;
    st_in.spie = st_spie;
    st_in.spp  = st_spp;
    st_in.mpie = st_mpie;
    st_in.mpp  = st_mpp;
  end

  trap_irq_pick #(.NIRQ(NIRQ), .IW(IW)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend     (irq_pend),
    .en       (irq_en),
    .deleg    (irq_deleg),
    .cur_priv (cur_priv),
    .st       (st_in),
    .hit      (irq_hit),
    .idx      (irq_idx),
    .allowed  (irq_allowed)
  );

  trap_route #(.XLEN(XLEN), .NIRQ(NIRQ), .IW(IW), .BKPT(BKPT)) u_route (
    .exc_req    (exc_req),
    .exc_cause  (exc_cause),
    .exc_deleg  (exc_deleg),
    .irq_hit    (irq_hit),
    .irq_idx    (irq_idx),
    .irq_deleg  (irq_deleg),
    .cur_priv   (cur_priv),
    .take       (take),
    .is_irq     (is_irq),
    .to_s       (to_s),
    .bkpt       (bkpt),
    .cause_word (cause_word)
  );

  trap_commit #(.XLEN(XLEN)) u_commit (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .to_s       (to_s),
    .is_irq     (is_irq),
    .bkpt       (bkpt),
    .cause_word (cause_word),
    .exc_epc    (exc_epc),
    .cur_pc     (cur_pc),
    .has_bad    (exc_has_bad),
    .bad_addr   (exc_bad),
    .stvec      (stvec),
    .mtvec      (mtvec),
    .cur_priv   (cur_priv),
    .st         (st_in),
    .fire_q     (trap_fire),
    .wr_s_q     (trap_wr_s),
    .wr_m_q     (trap_wr_m),
    .wr_bad_q   (trap_wr_bad),
    .pc_q       (trap_pc),
    .priv_q     (trap_priv),
    .cause_q    (trap_cause),
    .epc_q      (trap_epc),
    .bad_q      (trap_bad),
    .st_q       (st_out),
    .halted_q   (halted)
  );

  assign trap_sie  = st_out.sie;
  assign trap_spie = st_out.spie;
  assign trap_spp  = st_out.spp;
  assign trap_mie  = st_out.mie;
  assign trap_mpie = st_out.mpie;
  assign trap_mpp  = st_out.mpp;

  // R10
  exc_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && exc_cause != XLEN'(BKPT)) |=> (trap_fire && !trap_cause[XLEN-1]));

  // R12
  pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fire |-> (trap_pc[1:0] == 2'b00));

  // R5
  mach_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cur_priv == PRIV_M) |=> (trap_priv == PRIV_M && trap_wr_m));

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_req && !irq_hit) |=> (!trap_fire && $stable(trap_pc) && $stable(trap_cause)));

endmodule

// File: tb/trap_entry_unit_bench.sv
module trap_entry_unit_bench;
  localparam int XLEN = 32;
  localparam int NIRQ = 12;
  localparam int BKPT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NIRQ-1:0] pend = '0, en = '0, ideleg = '0;
  logic [XLEN-1:0] edeleg = '0;
  logic [1:0]      priv = 2'd3;
  logic            uie = 0, sie = 0, mie = 0, spie = 0, spp = 0, mpie = 0;
  logic [1:0]      mpp = 2'd0;
  logic [XLEN-1:0] stvec = 32'h1000_0103, mtvec = 32'h2000_0202, cur_pc = '0;
  logic            exc_req = 0, has_bad = 0;
  logic [XLEN-1:0] exc_cause = '0, exc_epc = '0, bad = '0;

  logic            o_fire, o_ws, o_wm, o_wb, o_sie, o_spie, o_spp, o_mie, o_mpie, o_halt;
  logic [XLEN-1:0] o_pc, o_cause, o_epc, o_bad;
  logic [1:0]      o_priv, o_mpp;

  trap_entry_unit #(.XLEN(XLEN), .NIRQ(NIRQ), .BKPT(BKPT)) u_trap_entry_unit (
    .clk(clk), .rst_n(rst_n), .irq_pend(pend), .irq_en(en), .irq_deleg(ideleg),
    .exc_deleg(edeleg), .cur_priv(priv), .st_uie(uie), .st_sie(sie), .st_mie(mie),
    .st_spie(spie), .st_spp(spp), .st_mpie(mpie), .st_mpp(mpp), .stvec(stvec),
    .mtvec(mtvec), .cur_pc(cur_pc), .exc_req(exc_req), .exc_cause(exc_cause),
    .exc_epc(exc_epc), .exc_has_bad(has_bad), .exc_bad(bad),
    .trap_fire(o_fire), .trap_wr_s(o_ws), .trap_wr_m(o_wm), .trap_wr_bad(o_wb),
    .trap_pc(o_pc), .trap_priv(o_priv), .trap_cause(o_cause), .trap_epc(o_epc),
    .trap_bad(o_bad), .trap_sie(o_sie), .trap_spie(o_spie), .trap_spp(o_spp),
    .trap_mie(o_mie), .trap_mpie(o_mpie), .trap_mpp(o_mpp), .halted(o_halt)
  );

  int checks = 0;
  int errors = 0;

  logic            e_fire = 0, e_ws = 0, e_wm = 0, e_wb = 0, e_halt = 0;
  logic [XLEN-1:0] e_pc = '0, e_cause = '0, e_epc = '0, e_bad = '0;
  logic [1:0]      e_priv = 2'd3, e_mpp = 2'd0;
  logic            e_sie = 0, e_spie = 0, e_spp = 0, e_mie = 0, e_mpie = 0;
  logic            last_s = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference: restated from the requirements
  task automatic model();
    int              idx;
    logic            ok, d, pie;
    logic [XLEN-1:0] cw, ep;
    e_fire = 0; e_ws = 0; e_wm = 0; e_wb = 0;
    idx = -1; d = 0; cw = '0; ep = '0;
    if (exc_req) begin
      if (exc_cause == XLEN'(BKPT)) begin
        e_halt = 1;
        return;
      end
      cw = exc_cause;
      ep = exc_epc;
      d  = (exc_cause < 32) ? edeleg[exc_cause[4:0]] : 1'b0;
      if (has_bad) begin
        e_wb  = 1;
        e_bad = bad;
      end
    end else begin
      for (int i = 0; i < NIRQ; i++) begin
        if (idx < 0 && pend[i] && en[i]) begin
          ok = ideleg[i] ? (priv == 2'd0 || (priv == 2'd1 && sie))
                         : (priv != 2'd3 || mie);
          if (ok) idx = i;
        end
      end
      if (idx < 0) return;
      cw = 32'h8000_0000 + XLEN'(idx);
      ep = cur_pc;
      d  = ideleg[idx];
    end
    e_fire  = 1;
    pie     = (priv == 2'd0) ? uie : (priv == 2'd1) ? sie : mie;
    e_cause = cw;
    e_epc   = ep;
    if (d && priv <= 2'd1) begin
      e_ws = 1; last_s = 1;
      e_pc = {stvec[31:2], 2'b00};
      e_priv = 2'd1; e_sie = 0; e_spie = pie; e_spp = priv[0];
      e_mie = mie; e_mpie = mpie; e_mpp = mpp;
    end else begin
      e_wm = 1; last_s = 0;
      e_pc = {mtvec[31:2], 2'b00};
      e_priv = 2'd3; e_mie = 0; e_mpie = pie; e_mpp = priv;
      e_sie = sie; e_spie = spie; e_spp = spp;
    end
  endtask

  task automatic trial(input string tag);
    string lv;
    model();
    @(posedge clk);
    #1;
    lv = last_s ? "R6" : "R7";
    chk(tag, "fire", 64'(o_fire), 64'(e_fire));
    chk(tag, "wr_s", 64'(o_ws), 64'(e_ws));
    chk(tag, "wr_m", 64'(o_wm), 64'(e_wm));
    chk("R8", "wr_bad", 64'(o_wb), 64'(e_wb));
    chk("R12", "pc", 64'(o_pc), 64'(e_pc));
    chk("R2", "cause", 64'(o_cause), 64'(e_cause));
    chk(lv, "epc", 64'(o_epc), 64'(e_epc));
    chk(lv, "priv", 64'(o_priv), 64'(e_priv));
    chk(lv, "sie", 64'(o_sie), 64'(e_sie));
    chk(lv, "spie", 64'(o_spie), 64'(e_spie));
    chk(lv, "spp", 64'(o_spp), 64'(e_spp));
    chk(lv, "mie", 64'(o_mie), 64'(e_mie));
    chk(lv, "mpie", 64'(o_mpie), 64'(e_mpie));
    chk(lv, "mpp", 64'(o_mpp), 64'(e_mpp));
    chk("R8", "bad", 64'(o_bad), 64'(e_bad));
    chk("R9", "halted", 64'(o_halt), 64'(e_halt));
  endtask

  task automatic set_ie(input int v);
    uie = v[2]; sie = v[1]; mie = v[0];
  endtask

  logic [31:0] lfsr = 32'h1234_5678;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk("R1", "fire", 64'(o_fire), 0);
    chk("R1", "wr_s", 64'(o_ws), 0);
    chk("R1", "wr_m", 64'(o_wm), 0);
    chk("R1", "wr_bad", 64'(o_wb), 0);
    chk("R1", "halted", 64'(o_halt), 0);
    chk("R1", "priv", 64'(o_priv), 3);
    chk("R1", "pc", 64'(o_pc), 0);
    chk("R1", "cause", 64'(o_cause), 0);

    // R13 nothing enabled at any level
    for (int k = 0; k < 3; k++) begin
      priv = (k == 2) ? 2'd3 : 2'(k);
      set_ie(7); pend = '1; en = '0; ideleg = 12'h5A5;
      trial("R13");
    end
    // R3 machine level with its enable clear, nothing delegated
    priv = 2'd3; set_ie(6); pend = '1; en = '1; ideleg = '0;
    trial("R3");
    // R4 delegated lines never taken at machine level
    priv = 2'd3; set_ie(7); ideleg = '1;
    trial("R4");
    // R4 supervisor with its enable clear, all delegated
    priv = 2'd1; set_ie(5); ideleg = '1;
    trial("R4");

    // single-line sweep over privilege, enables and delegation
    for (int k = 0; k < 3; k++)
      for (int ie = 0; ie < 8; ie++)
        for (int i = 0; i < NIRQ; i++)
          for (int d = 0; d < 2; d++) begin
            priv = (k == 2) ? 2'd3 : 2'(k);
            set_ie(ie);
            spie = i[0]; spp = i[1]; mpie = ~i[0]; mpp = 2'(i + k);
            pend = NIRQ'(1) << i;
            en = '1;
            ideleg = (d != 0) ? pend : ~pend;
            cur_pc = 32'h0008_0000 + XLEN'(i * 4 + k * 256 + ie * 64);
            has_bad = 1'b1;
            trial((d != 0) ? "R4" : "R3");
          end

    // multi-line patterns: lowest allowed line wins (R2)
    for (int n = 0; n < 300; n++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      pend = lfsr[11:0]; en = lfsr[23:12]; ideleg = {lfsr[31:24], lfsr[3:0]};
      priv = (lfsr[5:4] == 2'd2) ? 2'd3 : lfsr[5:4];
      uie = lfsr[6]; sie = lfsr[7]; mie = lfsr[8];
      spie = lfsr[9]; spp = lfsr[10]; mpie = lfsr[11]; mpp = lfsr[13:12];
      has_bad = lfsr[14];
      cur_pc = lfsr ^ 32'h0F0F_0000;
      trial("R2");
    end

    // exceptions: delegation by cause, out-of-range cause, bad address (R5, R8)
    pend = '0; en = '0; exc_req = 1'b1; edeleg = 32'hAAAA_5555;
    for (int k = 0; k < 3; k++)
      for (int c = 0; c < 26; c++) begin
        if (c == BKPT) continue;
        priv = (k == 2) ? 2'd3 : 2'(k);
        set_ie(c % 8);
        exc_cause = (c == 24) ? 32'd40 : (c == 25) ? 32'd33 : XLEN'(c);
        if (c >= 24) edeleg = '1; else edeleg = 32'hAAAA_5555;
        exc_epc = 32'h4000_0000 + XLEN'(c * 4 + k);
        has_bad = c[0];
        bad = 32'hBAD0_0000 + XLEN'(c * 16 + k);
        trial("R5");
      end

    // R10 exception wins over a same-cycle interrupt
    priv = 2'd0; set_ie(7); pend = '1; en = '1; ideleg = '0;
    exc_req = 1'b1; exc_cause = 32'd2; has_bad = 1'b0; exc_epc = 32'h5000_0010;
    trial("R10");
    exc_cause = 32'd5; has_bad = 1'b1; bad = 32'hDEAD_0004; exc_epc = 32'h5000_0020;
    trial("R10");

    // R11 strobes drop when the request goes away
    exc_req = 1'b0; pend = '0;
    trial("R11");

    // R9 breakpoint: no trap even with an allowed interrupt, halt is sticky
    exc_req = 1'b1; exc_cause = 32'd3; pend = 12'h010; en = '1; has_bad = 1'b1;
    bad = 32'h1111_2222;
    trial("R9");
    exc_req = 1'b0; pend = '0;
    trial("R9");
    pend = 12'h001; priv = 2'd0;
    trial("R9");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL R11 watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule